// File: doc/BRIEF.md
# Consecutive-Conversion Fault Filter

This block removes noise from threshold comparisons in a monitoring subsystem. It sits between the raw comparators and the event logic. When a measurement completes, the converter pulses a strobe. On each such strobe, every channel of the filter samples its raw condition flag, for example "reading above limit". A channel reports its condition as qualified only once the flag has been present on a programmed number of back-to-back conversions.

A 2-bit depth selector picks how many conversions are required. The mapping is deliberately not linear: 1, 2, 4 or 6. Each channel has its own run counter, so for example two zone comparisons and one critical comparison are filtered independently. A conversion that arrives without the condition restarts that channel's run. The selector is shared by all channels. Changing it, or raising the clear input, discards every run in progress. The clear input is used when the host side enters shutdown. The cost of the filtering is latency: detection is delayed by the programmed depth times the conversion period.

Top module: `fault_queue_filter`

## Requirements
- R1: After reset every bit of `cond_valid` is 0 and every run counter is empty.
- R2: The depth selector encodes the required run length as 2'b00 = 1, 2'b01 = 2, 2'b10 = 4 and 2'b11 = 6 conversions. With the selector held, `cond_valid[i]` rises on the clock edge that registers the N-th consecutive strobe with `cond_raw[i]` = 1, and not before.
- R3: Between strobes, `cond_raw` has no effect. Absent a strobe, a clear or a selector change, `cond_valid` holds its value and the run counters keep their values.
- R4: A strobe with `cond_raw[i]` = 0 empties channel i's run and drops `cond_valid[i]` on that edge. The next qualification again needs the full run length.
- R5: While the condition keeps being present on later strobes, `cond_valid[i]` stays 1. The counter saturates at the run length and never wraps.
- R6: `clr` = 1 empties all runs and forces `cond_valid` to 0 on the next edge. A strobe in the same cycle is discarded.
- R7: A cycle in which `depth_sel` differs from its value in the previous cycle empties all runs and forces `cond_valid` to 0 on the next edge. A strobe in that cycle is discarded.
- R8: Channels are independent. Each channel's run depends only on its own `cond_raw` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_done | input | 1 | One-cycle strobe marking a completed conversion |
| cond_raw | input | N_CH | Raw per-channel condition flags, sampled on `conv_done` |
| depth_sel | input | 2 | Run-length selector (see R2) |
| clr | input | 1 | Synchronous flush of all runs |
| cond_valid | output | N_CH | Qualified per-channel condition |

## Verification
Two pairs of events can land in the same cycle: a conversion strobe with a clear, and a conversion strobe with a depth-selector change. Both are provoked by partly filling a run, then presenting a strobe with the condition present in the very cycle the flush happens. The result is judged by counting how many further strobes are needed before the output rises. The discarded strobe must not have advanced the count, so exactly the full new run length is needed.

// File: rtl/fq_pkg.sv
package fq_pkg;

  localparam int FQ_SEL_W     = 2;
  localparam int FQ_MAX_DEPTH = 6;
  localparam int FQ_CNT_W     = $clog2(FQ_MAX_DEPTH + 1);

  typedef logic [FQ_SEL_W-1:0] fq_sel_t;
  typedef logic [FQ_CNT_W-1:0] fq_cnt_t;

  // Run length for each selector value: 1, 2, 4, 6.
  function automatic fq_cnt_t fq_run_len(input fq_sel_t sel);
    fq_cnt_t len;
    case (sel)
      2'b00:   len = FQ_CNT_W'(1);
      2'b01:   len = FQ_CNT_W'(2);
      2'b10:   len = FQ_CNT_W'(4);
      default: len = FQ_CNT_W'(6);
    endcase
    return len;
  endfunction

endpackage

// File: rtl/fq_reset_sync.sv
module fq_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/fq_sel_tracker.sv
module fq_sel_tracker
  import fq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fq_sel_t sel,
  output fq_cnt_t run_len,
  output logic    sel_changed
);

  fq_sel_t sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel;
  end

  assign sel_changed = (sel != sel_q);
  assign run_len     = fq_run_len(sel);

endmodule

// File: rtl/fq_run_counter.sv
module fq_run_counter
  import fq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sample_en,
  input  logic    raw,
  input  logic    flush,
  input  fq_cnt_t run_len,
  output logic    qualified
);

  fq_cnt_t run_q, run_d;
  logic    qual_q, qual_d;
  logic    upd_en;

  always_comb begin
    run_d = run_q;
    if (flush) begin
      run_d = '0;
    end else if (sample_en) begin
      if (!raw)                 run_d = '0;
      else if (run_q < run_len) run_d = run_q + 1'b1;
    end
    qual_d = !flush && (run_d == run_len);
  end

  assign upd_en = flush | sample_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else if (upd_en) begin
      run_q  <= run_d;
      qual_q <= qual_d;
    end
  end

  assign qualified = qual_q;

endmodule

// File: rtl/fault_queue_filter.sv
module fault_queue_filter
  import fq_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_done,
  input  logic [N_CH-1:0]     cond_raw,
  input  logic [FQ_SEL_W-1:0] depth_sel,
  input  logic                clr,
  output logic [N_CH-1:0]     cond_valid
);

  logic    rst_n_int;
  fq_cnt_t run_len;
  logic    sel_changed;
  logic    flush;

  fq_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fq_sel_tracker u_sel (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .sel         (depth_sel),
    .run_len     (run_len),
    .sel_changed (sel_changed)
  );

  assign flush = clr | sel_changed;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    fq_run_counter u_cnt (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .sample_en (conv_done),
      .raw       (cond_raw[g]),
      .flush     (flush),
      .run_len   (run_len),
      .qualified (cond_valid[g])
    );
  end

endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter int N_CH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_done,
  input logic [N_CH-1:0] cond_raw,
  input logic [1:0]      depth_sel,
  input logic            clr,
  input logic [N_CH-1:0] cond_valid
);

  // R3
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !clr && $stable(depth_sel)) |=> $stable(cond_valid));

  // R6
  clear_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cond_valid == '0));

  // R7
  sel_change_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(depth_sel) |=> (cond_valid == '0));

  // R4
  absent_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !clr && $stable(depth_sel)) |=> ((cond_valid & ~$past(cond_raw)) == '0));

  // R5
  keep_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !clr && $stable(depth_sel)) |=>
      (($past(cond_valid) & $past(cond_raw) & ~cond_valid) == '0));

  // R2
  single_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !clr && $stable(depth_sel) && depth_sel == 2'b00) |=>
      (cond_valid == $past(cond_raw)));

endmodule

bind fault_queue_filter fq_checker #(.N_CH(N_CH)) chk_i (.*);

// File: tb/fault_queue_filter_tb_top.sv
module fault_queue_filter_tb_top;

  localparam int N = 3;
  localparam logic [N-1:0] ALL = '1;

  logic         clk;
  logic         rst_n;
  logic         conv_done;
  logic [N-1:0] cond_raw;
  logic [1:0]   depth_sel;
  logic         clr;
  logic [N-1:0] cond_valid;

  int n_chk;
  int n_bad;

  fault_queue_filter #(.N_CH(N)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .cond_raw   (cond_raw),
    .depth_sel  (depth_sel),
    .clr        (clr),
    .cond_valid (cond_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: cond_valid got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // One strobe; the output is sampled at the following falling edge.
  task automatic strobe(input logic [N-1:0] r);
    @(negedge clk);
    conv_done = 1'b1;
    cond_raw  = r;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush_all();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic set_sel(input logic [1:0] s);
    @(negedge clk);
    depth_sel = s;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset", cond_valid, '0);
    idle(3);
    check("R1 idle after reset", cond_valid, '0);
  endtask

  task automatic t_depth(input logic [1:0] s, input int len);
    set_sel(s);
    flush_all();
    for (int k = 1; k <= len; k++) begin
      strobe(ALL);
      check($sformatf("R2 sel=%b strobe %0d", s, k), cond_valid, (k == len) ? ALL : '0);
    end
    for (int k = 0; k < 9; k++) strobe(ALL);
    check($sformatf("R5 sel=%b saturated", s), cond_valid, ALL);
    strobe('0);
    check($sformatf("R4 sel=%b absent drops", s), cond_valid, '0);
  endtask

  task automatic t_restart();
    set_sel(2'b10);
    flush_all();
    repeat (3) strobe(ALL);
    strobe('0);
    repeat (3) strobe(ALL);
    check("R4 restart after gap, 3 of 4", cond_valid, '0);
    strobe(ALL);
    check("R4 restart after gap, 4 of 4", cond_valid, ALL);
  endtask

  task automatic t_no_strobe();
    set_sel(2'b01);
    flush_all();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cond_raw = (k % 2 == 0) ? ALL : '0;
    end
    strobe(ALL);
    check("R3 raw toggles ignored, one strobe", cond_valid, '0);
    strobe(ALL);
    check("R3 second strobe qualifies", cond_valid, ALL);
    @(negedge clk);
    cond_raw = '0;
    idle(5);
    check("R3 raw low without strobe holds", cond_valid, ALL);
  endtask

  task automatic t_clear();
    set_sel(2'b00);
    flush_all();
    strobe(ALL);
    check("R6 setup qualified", cond_valid, ALL);
    flush_all();
    check("R6 clear drops output", cond_valid, '0);
    set_sel(2'b01);
    strobe(ALL);
    @(negedge clk);
    conv_done = 1'b1;
    cond_raw  = ALL;
    clr       = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    clr       = 1'b0;
    check("R6 strobe with clear discarded", cond_valid, '0);
    strobe(ALL);
    check("R6 one strobe after clear", cond_valid, '0);
    strobe(ALL);
    check("R6 two strobes after clear", cond_valid, ALL);
  endtask

  task automatic t_sel_change();
    set_sel(2'b01);
    flush_all();
    strobe(ALL);
    @(negedge clk);
    depth_sel = 2'b11;
    conv_done = 1'b1;
    cond_raw  = ALL;
    @(negedge clk);
    conv_done = 1'b0;
    check("R7 strobe with selector change discarded", cond_valid, '0);
    for (int k = 1; k <= 6; k++) begin
      strobe(ALL);
      if (k >= 5)
        check($sformatf("R7 new run, strobe %0d", k), cond_valid, (k == 6) ? ALL : '0);
    end
    set_sel(2'b00);
    check("R7 selector change drops output", cond_valid, '0);
  endtask

  task automatic t_channels();
    set_sel(2'b01);
    flush_all();
    strobe(3'b101);
    strobe(3'b011);
    check("R8 channels counted separately", cond_valid, 3'b001);
    strobe(3'b110);
    check("R8 channel 1 qualifies alone", cond_valid, 3'b010);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    conv_done = 1'b0;
    cond_raw  = '0;
    depth_sel = 2'b00;
    clr       = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_depth(2'b00, 1);
    t_depth(2'b01, 2);
    t_depth(2'b10, 4);
    t_depth(2'b11, 6);
    t_restart();
    t_no_strobe();
    t_clear();
    t_sel_change();
    t_channels();
    summary();
    $finish;
  end

endmodule